// File: doc/BRIEF.md
# USB Endpoint Transmit FIFO Bank

This block holds outgoing (IN-direction) packet bytes for two device endpoints: the control endpoint EP0 and a bulk endpoint EP1 whose direction is configurable. A local microcontroller loads packet bytes through a write-only register bus. A DMA agent loads EP1 with 16-bit words at a dedicated address. The serial engine of the USB device drains bytes from the head of each queue, one per read strobe. Each queue has 64 bytes of storage and reports its byte count.

Protocol events discard a queue's contents. For EP0, these events are a host ACK and the arrival of a SETUP packet. For EP1, they are a host ACK and a software clear strobe. A bus reset empties both queues. Each endpoint raises a packet-ready interrupt request while its queue is empty, which tells the microcontroller that it may load the next packet. While EP1 is set to receive, the block ignores everything aimed at EP1's transmit queue.

Top module: `usb_tx_fifo_bank`

## Requirements
- R1: A bus write (`wr_en`=1) to address C0h appends `wr_data[7:0]` to the EP0 queue, and `ep0_count` rises by one on the next clock edge.
- R2: With EP1 set to transmit, a write to C1h appends `wr_data[7:0]` to EP1. A write to 41h appends two bytes to EP1, `wr_data[7:0]` first and then `wr_data[15:8]`.
- R3: Each queue is first-in first-out. `epN_rd_data` shows the oldest byte, and a read strobe removes it. A read strobe on an empty queue leaves the count at 0. A write and a read in the same cycle leave the count unchanged.
- R4: `ep0_ack` or `ep0_setup` empties the EP0 queue on the next edge.
- R5: `ep1_ack` or `ep1_clr` empties the EP1 queue on the next edge.
- R6: A clear event takes priority over a write to the same queue in the same cycle, so the queue is empty afterwards.
- R7: While `ep1_dir_rx`=1, writes to C1h and 41h and EP1 read strobes have no effect on the EP1 queue, and `ep1_irq` is 0.
- R8: A byte that would exceed 64 stored bytes is dropped and sets the queue's sticky overflow flag. On a wide write with only one slot free, the low byte is kept. Only that queue's clear events or a reset clear the flag.
- R9: `ep0_irq` is 1 exactly when the EP0 queue is empty. `ep1_irq` is 1 exactly when the EP1 queue is empty and EP1 is set to transmit.
- R10: An asynchronous reset (`rst_n`=0) or a synchronous `bus_reset` empties both queues and clears both overflow flags.
- R11: Writes to any other address, and bus cycles with `wr_en`=0, change neither queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Synchronous USB bus reset strobe |
| wr_en | input | 1 | Register bus write strobe |
| wr_addr | input | 8 | Register bus write address |
| wr_data | input | 16 | Write data; bits 15:8 used only at 41h |
| ep1_dir_rx | input | 1 | EP1 configured for receive |
| ep1_clr | input | 1 | Software clear strobe for EP1 queue |
| ep0_ack | input | 1 | Host ACK for EP0 transmission |
| ep0_setup | input | 1 | SETUP packet received |
| ep1_ack | input | 1 | Host ACK for EP1 transmission |
| ep0_rd | input | 1 | Serial engine pops EP0 head byte |
| ep1_rd | input | 1 | Serial engine pops EP1 head byte |
| ep0_rd_data | output | 8 | EP0 head byte |
| ep1_rd_data | output | 8 | EP1 head byte |
| ep0_count | output | 7 | EP0 stored byte count |
| ep1_count | output | 7 | EP1 stored byte count |
| ep0_ovf | output | 1 | EP0 sticky overflow flag |
| ep1_ovf | output | 1 | EP1 sticky overflow flag |
| ep0_irq | output | 1 | EP0 packet-ready interrupt request |
| ep1_irq | output | 1 | EP1 packet-ready interrupt request |

## Verification
Several functions can fall in the same cycle, and the bench drives each pair together in one bus cycle. A write can coincide with a clear event: an EP0 byte write lands with `ep0_ack`, and a 41h wide write lands with `ep1_clr`. The judgement is that the count reads 0 on the next sample. A write can also coincide with a read strobe on a one-byte queue. The judgement is that the count holds at 1 and the head byte becomes the newly written one.

// File: rtl/usb_txf_pkg.sv
package usb_txf_pkg;
    localparam int unsigned TXF_DEPTH = 64;
    localparam int unsigned TXF_CNT_W = $clog2(TXF_DEPTH + 1);

    localparam logic [7:0] ADDR_EP0      = 8'hC0;
    localparam logic [7:0] ADDR_EP1      = 8'hC1;
    localparam logic [7:0] ADDR_EP1_WIDE = 8'h41;

    typedef enum logic [1:0] {
        PUSH_NONE = 2'd0,
        PUSH_ONE  = 2'd1,
        PUSH_TWO  = 2'd2
    } push_e;
endpackage

// File: rtl/txf_addr_decode.sv
module txf_addr_decode
    import usb_txf_pkg::*;
(
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic       ep1_dir_rx,
    output push_e      ep0_push,
    output push_e      ep1_push
);
    always_comb begin
        ep0_push = PUSH_NONE;
        ep1_push = PUSH_NONE;
        if (wr_en) begin
            if (wr_addr == ADDR_EP0) begin
                ep0_push = PUSH_ONE;
            end
            if (!ep1_dir_rx) begin
                if (wr_addr == ADDR_EP1) begin
                    ep1_push = PUSH_ONE;
                end else if (wr_addr == ADDR_EP1_WIDE) begin
                    ep1_push = PUSH_TWO;
                end
            end
        end
    end
endmodule

// File: rtl/txf_store.sv
module txf_store
    import usb_txf_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned PW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  push_e         push,
    input  logic [7:0]    din_lo,
    input  logic [7:0]    din_hi,
    input  logic          pop,
    output logic [7:0]    dout,
    output logic [CW-1:0] count,
    output logic          ovf
);
    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovf;
    } state_t;

    state_t        st_d, st_q;
    logic [CW-1:0] wr_n;
    logic [7:0]    mem [DEPTH];

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input logic [CW-1:0] k);
        int unsigned s;
        s = int'(p) + int'(k);
        if (s >= DEPTH) s = s - DEPTH;
        return PW'(s);
    endfunction

    always_comb begin
        logic [CW-1:0] free;
        logic [CW-1:0] want;
        logic          pop_ok;
        st_d   = st_q;
        wr_n   = '0;
        free   = CW'(DEPTH) - st_q.cnt;
        want   = CW'(push);
        pop_ok = pop && (st_q.cnt != '0);
        if (flush) begin
            st_d = '0;
        end else begin
            if (want > free) begin
                wr_n     = free;
                st_d.ovf = 1'b1;
            end else begin
                wr_n = want;
            end
            st_d.wp  = adv(st_q.wp, wr_n);
            st_d.rp  = adv(st_q.rp, CW'(pop_ok));
            st_d.cnt = st_q.cnt + wr_n - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_n >= CW'(1)) mem[st_q.wp] <= din_lo;
        if (wr_n == CW'(2)) mem[adv(st_q.wp, CW'(1))] <= din_hi;
    end

    assign dout  = mem[st_q.rp];
    assign count = st_q.cnt;
    assign ovf   = st_q.ovf;
endmodule

// File: rtl/usb_tx_fifo_bank.sv
module usb_tx_fifo_bank
    import usb_txf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_reset,
    input  logic                 wr_en,
    input  logic [7:0]           wr_addr,
    input  logic [15:0]          wr_data,
    input  logic                 ep1_dir_rx,
    input  logic                 ep1_clr,
    input  logic                 ep0_ack,
    input  logic                 ep0_setup,
    input  logic                 ep1_ack,
    input  logic                 ep0_rd,
    input  logic                 ep1_rd,
    output logic [7:0]           ep0_rd_data,
    output logic [7:0]           ep1_rd_data,
    output logic [TXF_CNT_W-1:0] ep0_count,
    output logic [TXF_CNT_W-1:0] ep1_count,
    output logic                 ep0_ovf,
    output logic                 ep1_ovf,
    output logic                 ep0_irq,
    output logic                 ep1_irq
);
    localparam int unsigned N_EP = 2;

    push_e                push_v  [N_EP];
    logic                 flush_v [N_EP];
    logic                 pop_v   [N_EP];
    logic [7:0]           dout_v  [N_EP];
    logic [TXF_CNT_W-1:0] cnt_v   [N_EP];
    logic                 ovf_v   [N_EP];

    txf_addr_decode i_dec (
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .ep1_dir_rx (ep1_dir_rx),
        .ep0_push   (push_v[0]),
        .ep1_push   (push_v[1])
    );

    assign flush_v[0] = ep0_ack | ep0_setup | bus_reset;
    assign flush_v[1] = ep1_ack | ep1_clr | bus_reset;
    assign pop_v[0]   = ep0_rd;
    assign pop_v[1]   = ep1_rd & ~ep1_dir_rx;

    for (genvar g = 0; g < N_EP; g++) begin : g_ep
        txf_store #(.DEPTH(TXF_DEPTH)) i_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (flush_v[g]),
            .push   (push_v[g]),
            .din_lo (wr_data[7:0]),
            .din_hi (wr_data[15:8]),
            .pop    (pop_v[g]),
            .dout   (dout_v[g]),
            .count  (cnt_v[g]),
            .ovf    (ovf_v[g])
        );
    end

    assign ep0_rd_data = dout_v[0];
    assign ep1_rd_data = dout_v[1];
    assign ep0_count   = cnt_v[0];
    assign ep1_count   = cnt_v[1];
    assign ep0_ovf     = ovf_v[0];
    assign ep1_ovf     = ovf_v[1];
    assign ep0_irq     = (cnt_v[0] == '0);
    assign ep1_irq     = (cnt_v[1] == '0) && !ep1_dir_rx;
endmodule

// File: rtl/usb_tx_fifo_bank_chk.sv
module usb_tx_fifo_bank_chk
    import usb_txf_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_reset,
    input logic                 ep1_dir_rx,
    input logic                 ep1_clr,
    input logic                 ep0_ack,
    input logic                 ep0_setup,
    input logic                 ep1_ack,
    input logic [TXF_CNT_W-1:0] ep0_count,
    input logic [TXF_CNT_W-1:0] ep1_count,
    input logic                 ep0_ovf,
    input logic                 ep1_ovf
);
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (ep0_count <= TXF_CNT_W'(TXF_DEPTH)) && (ep1_count <= TXF_CNT_W'(TXF_DEPTH)));

    a_r4_ep0_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (ep0_ack || ep0_setup) |=> (ep0_count == '0) && !ep0_ovf);

    a_r5_ep1_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (ep1_ack || ep1_clr) |=> (ep1_count == '0) && !ep1_ovf);

    a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ep1_dir_rx && !ep1_ack && !ep1_clr && !bus_reset) |=> $stable(ep1_count));

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ep0_ovf && !ep0_ack && !ep0_setup && !bus_reset) |=> ep0_ovf);

    a_r10_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (ep0_count == '0) && (ep1_count == '0) && !ep0_ovf && !ep1_ovf);
endmodule

bind usb_tx_fifo_bank usb_tx_fifo_bank_chk i_chk (.*);

// File: tb/test_usb_tx_fifo_bank.sv
`timescale 1ns/1ps
module test_usb_tx_fifo_bank;
    import usb_txf_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset = 0, wr_en = 0, ep1_dir_rx = 0, ep1_clr = 0;
    logic ep0_ack = 0, ep0_setup = 0, ep1_ack = 0, ep0_rd = 0, ep1_rd = 0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  ep0_rd_data, ep1_rd_data;
    logic [TXF_CNT_W-1:0] ep0_count, ep1_count;
    logic ep0_ovf, ep1_ovf, ep0_irq, ep1_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    usb_tx_fifo_bank i_usb_tx_fifo_bank (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // wait for next falling edge (one rising edge passes), then drop strobes
    task automatic tick();
        @(negedge clk);
        wr_en = 0; bus_reset = 0; ep1_clr = 0; ep0_ack = 0;
        ep0_setup = 0; ep1_ack = 0; ep0_rd = 0; ep1_rd = 0;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
    endtask

    // {wr_en, addr, data, exp ep0_count, exp ep1_count}
    localparam int NV = 8;
    localparam logic [38:0] VEC [NV] = '{
        {1'b1, 8'hC0, 16'h0011, 7'd1, 7'd0},
        {1'b1, 8'hC0, 16'h0022, 7'd2, 7'd0},
        {1'b1, 8'hC1, 16'hEE33, 7'd2, 7'd1},
        {1'b1, 8'h41, 16'h5544, 7'd2, 7'd3},
        {1'b1, 8'hC2, 16'h9999, 7'd2, 7'd3},
        {1'b1, 8'hC0, 16'h0066, 7'd3, 7'd3},
        {1'b1, 8'h41, 16'h8877, 7'd3, 7'd5},
        {1'b0, 8'hC0, 16'h00AB, 7'd3, 7'd5}
    };

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state, R9 irq when empty
        chk("R10 cnt0", ep0_count, 0);
        chk("R10 cnt1", ep1_count, 0);
        chk("R10 ovf", {ep0_ovf, ep1_ovf}, 0);
        chk("R9 irq empty", {ep0_irq, ep1_irq}, 3);

        // R1 R2 R11 vector walk
        for (int i = 0; i < NV; i++) begin
            wr_en = VEC[i][38]; wr_addr = VEC[i][37:30]; wr_data = VEC[i][29:14];
            tick();
            chk("R1 ep0 count", ep0_count, int'(VEC[i][13:7]));
            chk("R2/R11 ep1 count", ep1_count, int'(VEC[i][6:0]));
        end
        chk("R9 irq nonempty", {ep0_irq, ep1_irq}, 0);

        // R3 drain order
        begin
            logic [7:0] e1 [5] = '{8'h33, 8'h44, 8'h55, 8'h77, 8'h88};
            logic [7:0] e0 [3] = '{8'h11, 8'h22, 8'h66};
            for (int k = 0; k < 5; k++) begin
                chk("R3 ep1 order", ep1_rd_data, e1[k]);
                ep1_rd = 1; tick();
            end
            for (int k = 0; k < 3; k++) begin
                chk("R3 ep0 order", ep0_rd_data, e0[k]);
                ep0_rd = 1; tick();
            end
        end
        chk("R3 drained", {ep0_count, ep1_count}, 0);
        ep0_rd = 1; tick();
        chk("R3 pop empty", ep0_count, 0);

        // R3 write and read same cycle
        bus_wr(8'hC0, 16'h00A1);
        wr_en = 1; wr_addr = 8'hC0; wr_data = 16'h00A2; ep0_rd = 1; tick();
        chk("R3 wr+rd count", ep0_count, 1);
        chk("R3 wr+rd head", ep0_rd_data, 8'hA2);

        // R6 write with ack
        wr_en = 1; wr_addr = 8'hC0; wr_data = 16'h00A3; ep0_ack = 1; tick();
        chk("R6 ep0 ack beats write", ep0_count, 0);
        // R4 setup
        bus_wr(8'hC0, 16'h0001); bus_wr(8'hC0, 16'h0002);
        ep0_setup = 1; tick();
        chk("R4 setup flush", ep0_count, 0);
        // R6 wide write with clr
        bus_wr(8'hC1, 16'h0005);
        wr_en = 1; wr_addr = 8'h41; wr_data = 16'h0607; ep1_clr = 1; tick();
        chk("R6 ep1 clr beats write", ep1_count, 0);
        // R5 ack
        bus_wr(8'h41, 16'h0908);
        ep1_ack = 1; tick();
        chk("R5 ep1 ack flush", ep1_count, 0);

        // R7 receive direction
        bus_wr(8'hC1, 16'h0001);
        ep1_dir_rx = 1;
        @(negedge clk);
        chk("R7 irq low rx", ep1_irq, 0);
        bus_wr(8'hC1, 16'h00F1);
        bus_wr(8'h41, 16'hF3F2);
        ep1_rd = 1; tick();
        chk("R7 rx ignores", ep1_count, 1);
        ep1_dir_rx = 0;
        @(negedge clk);
        chk("R7 head kept", ep1_rd_data, 8'h01);
        chk("R9 irq nonempty tx", ep1_irq, 0);
        ep1_dir_rx = 1; ep1_clr = 1; tick();
        ep1_dir_rx = 0;
        @(negedge clk);
        chk("R9 irq empty tx", ep1_irq, 1);

        // R8 overflow EP0
        for (int i = 0; i < 64; i++) bus_wr(8'hC0, 16'(i));
        chk("R8 ep0 full", ep0_count, 64);
        chk("R8 ep0 no ovf yet", ep0_ovf, 0);
        bus_wr(8'hC0, 16'h00AA);
        chk("R8 ep0 drop", ep0_count, 64);
        chk("R8 ep0 ovf", ep0_ovf, 1);
        chk("R8 ep0 head", ep0_rd_data, 0);
        ep0_rd = 1; tick();
        chk("R8 ovf sticky", ep0_ovf, 1);
        ep0_setup = 1; tick();
        chk("R8 ovf clear", {ep0_ovf, 7'(ep0_count)}, 0);

        // R8 overflow EP1 with wide write, one slot free
        for (int i = 0; i < 31; i++) bus_wr(8'h41, {8'(2*i+1), 8'(2*i)});
        bus_wr(8'hC1, 16'd62);
        chk("R8 ep1 63", ep1_count, 63);
        bus_wr(8'h41, 16'hBBAA);
        chk("R8 ep1 full", ep1_count, 64);
        chk("R8 ep1 ovf", ep1_ovf, 1);
        for (int i = 0; i < 63; i++) begin
            chk("R2 wide order", ep1_rd_data, i);
            ep1_rd = 1; tick();
        end
        chk("R8 low byte kept", ep1_rd_data, 8'hAA);

        // R10 bus reset
        bus_wr(8'hC0, 16'h0077);
        bus_reset = 1; tick();
        chk("R10 bus reset counts", {ep0_count, ep1_count}, 0);
        chk("R10 bus reset ovf", ep1_ovf, 0);
        // R10 hardware reset
        bus_wr(8'hC0, 16'h0078);
        rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
        chk("R10 hw reset", ep0_count, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule